// File: doc/BRIEF.md
# Coded-Ratio Programmable Clock Divider

This block turns a fast synchronous clock into a slower square wave whose division ratio comes from a 4-bit code. The two low code bits pick a base divisor from one of two tables. The processor table gives 2, 3, 5 or 7 and the bus table gives 4, 3, 5 or 9. The upper code bits scale that base by a power of two. The resulting ratio ranges from 2 up to 56 for the processor table and up to 72 for the bus table.

A phase-invert control flips the output polarity. An output-enable parks the output at logic low. The code, table select, invert and enable inputs are all sampled only at the counter's terminal count. Software can therefore rewrite them at any time without producing a short pulse, and every output period is a whole period of a single setting.

Within one period the output is high for the first floor(N/2) input cycles and low for the remaining N - floor(N/2). Even ratios therefore give an exact 50 % duty cycle. Reset clears the counter and holds the output low. The first full period begins on the first clock edge after reset is released.

Top module: `coded_clk_div`

## Requirements
- R1: With `bus_table`=0, code bits [1:0] = 0/1/2/3 select base divisor 2/3/5/7 (multiplier code bits [3:2] = 0 gives the ratio equal to the base).
- R2: With `bus_table`=1, code bits [1:0] = 0/1/2/3 select base divisor 4/3/5/9.
- R3: Code bits [3:2] = 0/1/2/3 multiply the base by 1/2/4/8, so code 4'b1111 gives ratio 56 (processor table) or 72 (bus table).
- R4: For ratio N, each output period lasts N input cycles: high for floor(N/2) cycles, then low for N - floor(N/2) cycles.
- R5: With `invert`=1 the output is the bit-wise inverse of the non-inverted waveform for the same ratio: low for floor(N/2) cycles, then high.
- R6: With `out_en`=0 the output stays at logic low for the whole period, regardless of `invert`.
- R7: Code, table select, invert and enable are sampled only on the clock edge that ends a period; values applied and withdrawn inside a period have no effect on the output.
- R8: While `rst_n`=0 the output is low, one edge after reset is asserted; the first period after release starts on the first edge with `rst_n`=1 and begins with the high phase.
- R9: Disabling and re-enabling take effect only at a period boundary, so a re-enabled output starts with a complete first phase and never emits a partial pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_code | input | 4 | Ratio code: [1:0] base select, [3:2] power-of-two multiplier |
| bus_table | input | 1 | 0 = processor base table, 1 = bus base table |
| invert | input | 1 | 1 inverts the output polarity |
| out_en | input | 1 | 1 = output runs, 0 = output parked low |
| clk_out | output | 1 | Divided clock level, registered |

## Verification
The bench builds the block with its default multiplier width of two bits. This makes the full 4-bit code space reachable, including the extreme ratios 2 and 72 and the largest processor ratio 56. Every period is scored cycle by cycle against a waveform that the bench derives from its own ratio tables. Each new setting is preceded by a deliberately wrong setting inside the running period, which exposes any sampling that happens outside the terminal count. Odd and even ratios, both polarities, disable and re-enable sequences, and a reset in the middle of a run are all covered.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Width of the base-select field at the bottom of the code.
  localparam int BASE_W = 2;

  // Base divisor for a select value; the bus table differs at 0 and 3.
  function automatic logic [3:0] base_div(input logic [1:0] sel, input logic bus_tbl);
    logic [3:0] b;
    unique case (sel)
      2'd0:    b = bus_tbl ? 4'd4 : 4'd2;
      2'd1:    b = 4'd3;
      2'd2:    b = 4'd5;
      default: b = bus_tbl ? 4'd9 : 4'd7;
    endcase
    return b;
  endfunction

  // High phase covers counts below floor(ratio/2).
  function automatic logic in_high_phase(input int cnt, input int ratio);
    return cnt < (ratio / 2);
  endfunction

endpackage

// File: rtl/cdiv_ratio_decode.sv
module cdiv_ratio_decode
  import cdiv_pkg::*;
#(
  parameter int MULT_W = 2,
  parameter int RAT_W  = 7
) (
  input  logic [BASE_W+MULT_W-1:0] code,
  input  logic                     bus_tbl,
  output logic [RAT_W-1:0]         ratio
);

  logic [RAT_W-1:0] stage [MULT_W+1];

  assign stage[0] = RAT_W'(base_div(code[BASE_W-1:0], bus_tbl));

  // Each multiplier bit doubles the shift of the one below it.
  for (genvar g = 0; g < MULT_W; g++) begin : g_mul
    assign stage[g+1] = code[BASE_W+g] ? (stage[g] << (2**g)) : stage[g];
  end

  assign ratio = stage[MULT_W];

endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int RAT_W     = 7,
  parameter int MAX_RATIO = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAT_W-1:0] ratio_in,
  input  logic             en_in,
  input  logic             inv_in,
  output logic             wrap,
  output logic             en_q,
  output logic             inv_q,
  output logic [RAT_W-1:0] nxt_cnt,
  output logic [RAT_W-1:0] nxt_ratio,
  output logic             nxt_en,
  output logic             nxt_inv
);

  logic [RAT_W-1:0] cnt_q;
  logic [RAT_W-1:0] ratio_q;

  // Ratio 1 after reset makes the first active edge a terminal count.
  assign wrap      = (cnt_q == ratio_q - 1'b1);
  assign nxt_cnt   = wrap ? '0 : cnt_q + 1'b1;
  assign nxt_ratio = wrap ? ratio_in : ratio_q;
  assign nxt_en    = wrap ? en_in : en_q;
  assign nxt_inv   = wrap ? inv_in : inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RAT_W'(1);
      en_q    <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      cnt_q   <= nxt_cnt;
      ratio_q <= nxt_ratio;
      en_q    <= nxt_en;
      inv_q   <= nxt_inv;
    end
  end

  p_cnt_below_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  p_hold_between_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(ratio_q) && $stable(en_q) && $stable(inv_q)));

  p_ratio_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ratio_q >= RAT_W'(2) && ratio_q <= RAT_W'(MAX_RATIO)));

endmodule

// File: rtl/cdiv_wave.sv
module cdiv_wave
  import cdiv_pkg::*;
#(
  parameter int RAT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAT_W-1:0] nxt_cnt,
  input  logic [RAT_W-1:0] nxt_ratio,
  input  logic             nxt_en,
  input  logic             nxt_inv,
  output logic             clk_out
);

  logic level_d;

  assign level_d = nxt_en & (in_high_phase(int'(nxt_cnt), int'(nxt_ratio)) ^ nxt_inv);

  always_ff @(posedge clk) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= level_d;
  end

endmodule

// File: rtl/coded_clk_div.sv
module coded_clk_div
  import cdiv_pkg::*;
#(
  parameter int MULT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BASE_W+MULT_W-1:0] div_code,
  input  logic                     bus_table,
  input  logic                     invert,
  input  logic                     out_en,
  output logic                     clk_out
);

  localparam int MAX_RATIO = 9 << ((1 << MULT_W) - 1);
  localparam int RAT_W     = $clog2(MAX_RATIO + 1);

  logic [RAT_W-1:0] dec_ratio;
  logic             wrap;
  logic             en_q;
  logic             inv_q;
  logic [RAT_W-1:0] nxt_cnt;
  logic [RAT_W-1:0] nxt_ratio;
  logic             nxt_en;
  logic             nxt_inv;

  cdiv_ratio_decode #(.MULT_W(MULT_W), .RAT_W(RAT_W)) decode_i (
    .code    (div_code),
    .bus_tbl (bus_table),
    .ratio   (dec_ratio)
  );

  cdiv_counter #(.RAT_W(RAT_W), .MAX_RATIO(MAX_RATIO)) counter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_in  (dec_ratio),
    .en_in     (out_en),
    .inv_in    (invert),
    .wrap      (wrap),
    .en_q      (en_q),
    .inv_q     (inv_q),
    .nxt_cnt   (nxt_cnt),
    .nxt_ratio (nxt_ratio),
    .nxt_en    (nxt_en),
    .nxt_inv   (nxt_inv)
  );

  cdiv_wave #(.RAT_W(RAT_W)) wave_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_cnt   (nxt_cnt),
    .nxt_ratio (nxt_ratio),
    .nxt_en    (nxt_en),
    .nxt_inv   (nxt_inv),
    .clk_out   (clk_out)
  );

  p_park_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !clk_out);

  p_reset_low_r8: assert property (@(posedge clk)
    !rst_n |=> !clk_out);

  p_rise_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_out) && !inv_q) |-> $past(wrap));

  p_enable_full_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (clk_out != inv_q));

endmodule

// File: tb/coded_clk_div_tb_top.sv
module coded_clk_div_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] div_code;
  logic       bus_table;
  logic       invert;
  logic       out_en;
  logic       clk_out;

  int    errors = 0;
  int    checks = 0;
  bit    mon_go = 1'b0;
  bit    done   = 1'b0;
  int    cur_n  = 2;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  coded_clk_div dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_code  (div_code),
    .bus_table (bus_table),
    .invert    (invert),
    .out_en    (out_en),
    .clk_out   (clk_out)
  );

  // Independent ratio model: table lookup times a power of two.
  function automatic int ref_ratio(logic [3:0] c, logic bus);
    int b;
    case (c[1:0])
      2'b00: b = bus ? 4 : 2;
      2'b01: b = 3;
      2'b10: b = 5;
      default: b = bus ? 9 : 7;
    endcase
    return b * (2 ** int'(c[3:2]));
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clk_out actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_seg(int n, bit inv, bit en, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(en ? ((i < n / 2) ^ inv) : 1'b0);
      tag_q.push_back(tag);
    end
  endtask

  task automatic apply(logic [3:0] c, logic tbl, logic inv, logic en);
    div_code  = c;
    bus_table = tbl;
    invert    = inv;
    out_en    = en;
  endtask

  // Called at the negedge just after a period starts; programs the next period.
  task automatic step(logic [3:0] c, logic tbl, logic inv, logic en, string tag);
    int n;
    apply(~c, ~tbl, ~inv, ~en);   // wrong values inside the period (R7)
    @(negedge clk);
    apply(c, tbl, inv, en);
    n = ref_ratio(c, tbl);
    push_seg(n, inv, en, tag);
    repeat (cur_n - 1) @(negedge clk);
    cur_n = n;
  endtask

  // Called with rst_n low at a negedge.
  task automatic start_run(logic [3:0] c, logic tbl, logic inv, logic en, string tag);
    apply(c, tbl, inv, en);
    cur_n = ref_ratio(c, tbl);
    push_seg(cur_n, inv, en, tag);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    mon_go = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain();
    repeat (cur_n + 1) @(negedge clk);
    mon_go = 1'b0;
    @(negedge clk);
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      bit    e;
      string t;
      @(negedge clk);
      if (mon_go && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(clk_out, e, t);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8: watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply(4'b0000, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(clk_out, 1'b0, "R8");
    @(negedge clk);
    check(clk_out, 1'b0, "R8");

    start_run(4'b0000, 1'b0, 1'b0, 1'b1, "R1");      // 2
    step(4'b0001, 1'b0, 1'b0, 1'b1, "R1");           // 3
    step(4'b0010, 1'b0, 1'b0, 1'b1, "R1");           // 5
    step(4'b0011, 1'b0, 1'b0, 1'b1, "R1");           // 7
    step(4'b0000, 1'b1, 1'b0, 1'b1, "R2");           // 4
    step(4'b0001, 1'b1, 1'b0, 1'b1, "R2");           // 3
    step(4'b0010, 1'b1, 1'b0, 1'b1, "R2");           // 5
    step(4'b0011, 1'b1, 1'b0, 1'b1, "R2");           // 9
    step(4'b1111, 1'b0, 1'b0, 1'b1, "R3");           // 56
    step(4'b1111, 1'b1, 1'b0, 1'b1, "R3");           // 72
    step(4'b0110, 1'b0, 1'b0, 1'b1, "R3");           // 10
    step(4'b1001, 1'b1, 1'b0, 1'b1, "R3");           // 12
    step(4'b0101, 1'b0, 1'b0, 1'b1, "R4");           // 6
    step(4'b0100, 1'b0, 1'b0, 1'b1, "R4");           // 4
    step(4'b0010, 1'b0, 1'b1, 1'b1, "R5");           // 5 inverted
    step(4'b0001, 1'b1, 1'b1, 1'b1, "R5");           // 3 inverted
    step(4'b0011, 1'b0, 1'b0, 1'b0, "R6");           // 7 parked
    step(4'b0001, 1'b0, 1'b0, 1'b1, "R9");           // 3 re-enabled
    step(4'b0000, 1'b0, 1'b1, 1'b0, "R6");           // 2 parked, inverted
    step(4'b0000, 1'b0, 1'b1, 1'b1, "R9");           // 2 re-enabled, inverted
    step(4'b0010, 1'b1, 1'b0, 1'b1, "R7");           // 5
    step(4'b0010, 1'b1, 1'b0, 1'b1, "R7");           // 5 again
    drain();

    // Reset in the middle of a run.
    rst_n = 1'b0;
    @(negedge clk);
    check(clk_out, 1'b0, "R8");
    exp_q.delete();
    tag_q.delete();
    start_run(4'b0011, 1'b1, 1'b0, 1'b1, "R8");      // 9
    step(4'b0111, 1'b0, 1'b0, 1'b1, "R8");           // 14
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule